// File: doc/BRIEF.md
# Snapshot-Latched Front-End Monitoring Counters

This block keeps the monitoring counters of a front-end channel group. It counts crossings for which a full event (header plus payload) was sent, events that had to be truncated, and each kind of timing command received. The counters saturate instead of wrapping. An event-counter reset clears all of them in one cycle.

Software cannot read a set of running counters consistently over a slow serial path. So a snapshot copies every live counter into a shadow bank on the same clock edge. A snapshot comes from a single-shot request or from a programmable periodic timer. The shadow bank is read through an address-indexed port. A snapshot-valid flag tells the reader that a fresh set is waiting, and the flag clears when it is read. Decoding of the command word and the slow-control transport are handled elsewhere.

Top module: `snap_mon_counters`

## Requirements
- R1: Counter 0 (accepted crossings) increments by one on each cycle with `crossValid`=1 and `headerOnly`=0. Cycles with `headerOnly`=1 or `crossValid`=0 leave it unchanged.
- R2: Counter 1 (truncated events) increments by one on each cycle with `truncEvt`=1.
- R3: Counter 2+i increments by one on each cycle with `cmdStrobe[i]`=1, independently for each i.
- R4: A cycle with `evtCntReset`=1 sets every counter to zero at that edge. An event in the same cycle is not counted.
- R5: When `evtCntReset` and a snapshot fall in the same cycle, the shadow bank receives the values from before the reset.
- R6: A counter at its maximum value (all ones) stays there on further increments.
- R7: With `periodCfg`=P>0, a snapshot occurs on the P-th edge after the timer is enabled and then every P edges. With `periodCfg`=0, no periodic snapshot occurs.
- R8: A cycle with `snapReq`=1 copies all counters at once into the shadow bank. The copy holds the values as they stood before that edge. `snapValid` reads 1 after that edge.
- R9: A cycle with `rdEn`=1 loads `rdData` at that edge with shadow entry `rdAddr`. The address map is 0 accepted, 1 truncated, 2+i command i. Addresses at or beyond 2+NUM_CMD read zero. `rdData` holds its value when `rdEn`=0.
- R10: The read clears `snapValid`, unless a snapshot happens in the same cycle, in which case the flag is set.
- R11: The shadow bank does not change between snapshots, whatever the live counters do.
- R12: After reset, `snapValid`=0, `rdData`=0 and every shadow entry reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crossValid | input | 1 | A crossing was processed this cycle |
| headerOnly | input | 1 | That crossing sent the header only |
| truncEvt | input | 1 | An event was truncated this cycle |
| cmdStrobe | input | NUM_CMD | One strobe per timing command kind |
| evtCntReset | input | 1 | Clear all event-related counters |
| snapReq | input | 1 | Single-shot snapshot request |
| periodCfg | input | PERIOD_W | Periodic snapshot interval in cycles; 0 disables |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Shadow entry to read |
| rdData | output | CNT_W | Registered read data |
| snapValid | output | 1 | Fresh snapshot not yet read |

## Verification
The timing of each result is as follows:
- Counter updates take effect at the edge that samples the stimulus.
- A snapshot or read requested in cycle n shows at the ports after edge n: `snapValid` for a snapshot, `rdData` for a read.
- A periodic snapshot appears exactly P edges after the timer is enabled or after the previous periodic snapshot.

The bench drives every input on the falling edge. It counts edges explicitly before sampling on a later falling edge. A read is sampled one edge after its request, and the periodic sweep checks the flag on every edge of the window, so early and late snapshots are both caught. Expected counts are accumulated arithmetically from the stimulus pattern. Saturation is checked on a narrow counter width.

// File: rtl/snap_mon_pkg.sv
package snap_mon_pkg;
  localparam int IDX_ACC   = 0;
  localparam int IDX_TRUNC = 1;
  localparam int IDX_CMD0  = 2;

  typedef struct packed {
    logic snap;      // copy live counters into shadow bank
    logic clearEvt;  // clear all event-related counters
  } snapCtrl_t;
endpackage

// File: rtl/snap_mon_control.sv
module snap_mon_control
  import snap_mon_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                snapReq,
  input  logic                evtCntReset,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic                rdEn,
  output snapCtrl_t           ctrl,
  output logic                snapValid
);
  logic [PERIOD_W-1:0] timerQ;
  logic                periodOn;
  logic                periodHit;

  assign periodOn  = (periodCfg != '0);
  assign periodHit = periodOn && (timerQ >= (periodCfg - 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timerQ <= '0;
    end else if (!periodOn || periodHit) begin
      timerQ <= '0;
    end else begin
      timerQ <= timerQ + 1'b1;
    end
  end

  assign ctrl.snap     = snapReq | periodHit;
  assign ctrl.clearEvt = evtCntReset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snapValid <= 1'b0;
    end else if (ctrl.snap) begin
      snapValid <= 1'b1;
    end else if (rdEn) begin
      snapValid <= 1'b0;
    end
  end
endmodule

// File: rtl/snap_mon_datapath.sv
module snap_mon_datapath
  import snap_mon_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_CMD = 6,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  snapCtrl_t          ctrl,
  input  logic               crossValid,
  input  logic               headerOnly,
  input  logic               truncEvt,
  input  logic [NUM_CMD-1:0] cmdStrobe,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [CNT_W-1:0]   rdData
);
  localparam int NUM_CNT = IDX_CMD0 + NUM_CMD;
  localparam int NUM_ADR = 2 ** ADDR_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_CNT-1:0] incVec;
  logic [CNT_W-1:0]   liveCnt   [NUM_CNT];
  logic [CNT_W-1:0]   shadowCnt [NUM_CNT];
  logic [CNT_W-1:0]   readTable [NUM_ADR];

  assign incVec[IDX_ACC]   = crossValid & ~headerOnly;
  assign incVec[IDX_TRUNC] = truncEvt;

  genvar g;
  generate
    for (g = 0; g < NUM_CMD; g++) begin : g_cmdInc
      assign incVec[IDX_CMD0 + g] = cmdStrobe[g];
    end

    for (g = 0; g < NUM_CNT; g++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (!rst_n || ctrl.clearEvt) begin
          liveCnt[g] <= '0;
        end else if (incVec[g] && (liveCnt[g] != CNT_MAX)) begin
          liveCnt[g] <= liveCnt[g] + 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          shadowCnt[g] <= '0;
        end else if (ctrl.snap) begin
          shadowCnt[g] <= liveCnt[g];
        end
      end
    end

    for (g = 0; g < NUM_ADR; g++) begin : g_rdMap
      if (g < NUM_CNT) begin : g_used
        assign readTable[g] = shadowCnt[g];
      end else begin : g_empty
        assign readTable[g] = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData <= '0;
    end else if (rdEn) begin
      rdData <= readTable[rdAddr];
    end
  end
endmodule

// File: rtl/snap_mon_counters.sv
module snap_mon_counters
  import snap_mon_pkg::*;
#(
  parameter  int CNT_W    = 32,
  parameter  int NUM_CMD  = 6,
  parameter  int PERIOD_W = 16,
  localparam int ADDR_W   = $clog2(IDX_CMD0 + NUM_CMD + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                crossValid,
  input  logic                headerOnly,
  input  logic                truncEvt,
  input  logic [NUM_CMD-1:0]  cmdStrobe,
  input  logic                evtCntReset,
  input  logic                snapReq,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [CNT_W-1:0]    rdData,
  output logic                snapValid
);
  snapCtrl_t ctrlS;
  logic      snapNow;

  assign snapNow = ctrlS.snap;

  snap_mon_control #(.PERIOD_W(PERIOD_W)) control_i (
    .clk(clk), .rst_n(rst_n), .snapReq(snapReq), .evtCntReset(evtCntReset),
    .periodCfg(periodCfg), .rdEn(rdEn), .ctrl(ctrlS), .snapValid(snapValid)
  );

  snap_mon_datapath #(.CNT_W(CNT_W), .NUM_CMD(NUM_CMD), .ADDR_W(ADDR_W)) datapath_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrlS), .crossValid(crossValid),
    .headerOnly(headerOnly), .truncEvt(truncEvt), .cmdStrobe(cmdStrobe),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/snap_mon_counters_chk.sv
module snap_mon_counters_chk #(
  parameter int CNT_W    = 32,
  parameter int PERIOD_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                snapReq,
  input logic                rdEn,
  input logic [PERIOD_W-1:0] periodCfg,
  input logic                snapNow,
  input logic                snapValid,
  input logic [CNT_W-1:0]    rdData
);
  p_snap_sets_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snapReq |=> snapValid);

  p_read_clears_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && !snapNow) |=> !snapValid);

  p_valid_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdEn && !snapNow) |=> $stable(snapValid));

  p_rddata_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |=> $stable(rdData));

  p_no_periodic_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((periodCfg == '0) && !snapReq) |-> !snapNow);
endmodule

bind snap_mon_counters snap_mon_counters_chk #(.CNT_W(CNT_W), .PERIOD_W(PERIOD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .snapReq(snapReq), .rdEn(rdEn), .periodCfg(periodCfg),
  .snapNow(snapNow), .snapValid(snapValid), .rdData(rdData)
);

// File: tb/snap_mon_counters_tb_top.sv
module snap_mon_counters_tb_top;
  localparam int CNT_W    = 4;
  localparam int NUM_CMD  = 3;
  localparam int PERIOD_W = 4;
  localparam int NUM_CNT  = 2 + NUM_CMD;
  localparam int ADDR_W   = 3;
  localparam int MAXV     = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic crossValid = 0, headerOnly = 0, truncEvt = 0, evtCntReset = 0, snapReq = 0, rdEn = 0;
  logic [NUM_CMD-1:0]  cmdStrobe = '0;
  logic [PERIOD_W-1:0] periodCfg = '0;
  logic [ADDR_W-1:0]   rdAddr = '0;
  logic [CNT_W-1:0]    rdData;
  logic                snapValid;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int expCnt [NUM_CNT];

  always #10 clk = ~clk;  // 50 MHz

  snap_mon_counters #(.CNT_W(CNT_W), .NUM_CMD(NUM_CMD), .PERIOD_W(PERIOD_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .crossValid(crossValid), .headerOnly(headerOnly),
    .truncEvt(truncEvt), .cmdStrobe(cmdStrobe), .evtCntReset(evtCntReset),
    .snapReq(snapReq), .periodCfg(periodCfg), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .snapValid(snapValid)
  );

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // hold the given inputs for exactly one rising edge
  task automatic drive(input logic cv, input logic ho, input logic tr,
                       input logic [NUM_CMD-1:0] cmd, input logic er, input logic sr);
    crossValid = cv; headerOnly = ho; truncEvt = tr; cmdStrobe = cmd;
    evtCntReset = er; snapReq = sr;
    @(negedge clk);
    crossValid = 0; headerOnly = 0; truncEvt = 0; cmdStrobe = '0;
    evtCntReset = 0; snapReq = 0;
  endtask

  task automatic readChk(input int addr, input int exp, input string what);
    rdEn = 1; rdAddr = ADDR_W'(addr);
    @(negedge clk);
    rdEn = 0;
    check(int'(rdData), exp, what);
  endtask

  task automatic readAll(input string what);
    for (int a = 0; a < NUM_CNT; a++) readChk(a, expCnt[a], what);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R12 reset state
    check(snapValid, 0, "R12 snapValid after reset");
    check(int'(rdData), 0, "R12 rdData after reset");
    for (int a = 0; a < 8; a++) readChk(a, 0, "R12 shadow zero after reset");

    // R1 R2 R3 mixed pattern
    for (int a = 0; a < NUM_CNT; a++) expCnt[a] = 0;
    for (int i = 0; i < 10; i++) begin
      logic [NUM_CMD-1:0] cmd;
      for (int j = 0; j < NUM_CMD; j++) begin
        cmd[j] = (i % (j + 2) == 0);
        if (cmd[j]) expCnt[2 + j]++;
      end
      if (i % 3 != 0) expCnt[0]++;
      if (i % 4 == 0) expCnt[1]++;
      drive(1'b1, (i % 3 == 0), (i % 4 == 0), cmd, 1'b0, 1'b0);
    end
    drive(1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0);  // headerOnly without crossing: no count
    check(snapValid, 0, "R8 no snapshot before request");
    drive(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b1);
    check(snapValid, 1, "R8 snapValid after single-shot");
    readChk(0, expCnt[0], "R1 accepted crossings");
    check(snapValid, 0, "R10 read clears snapValid");
    readChk(1, expCnt[1], "R2 truncated events");
    for (int j = 0; j < NUM_CMD; j++) readChk(2 + j, expCnt[2 + j], "R3 command count");
    for (int a = NUM_CNT; a < 8; a++) readChk(a, 0, "R9 unused address reads zero");

    // R8 events in the snapshot cycle are not in the copy; R11 shadow stable
    drive(1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b1);
    readChk(0, expCnt[0], "R8 snapshot holds pre-edge value");
    expCnt[0]++;
    drive(1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    expCnt[0]++;
    repeat (3) @(negedge clk);
    readChk(0, expCnt[0] - 2, "R11 shadow unchanged between snapshots");
    drive(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b1);
    readChk(0, expCnt[0], "R11 new snapshot shows live count");

    // R10 read and snapshot in same cycle: flag stays set
    rdEn = 1; rdAddr = 0; snapReq = 1;
    @(negedge clk);
    rdEn = 0; snapReq = 0;
    check(snapValid, 1, "R10 snapshot wins over read clear");
    readChk(1, expCnt[1], "R10 read after coincident");

    // R5 reset and snapshot coincide: pre-reset values latched
    drive(1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b1);
    readAll("R5 pre-reset values latched");
    drive(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b1);
    for (int a = 0; a < NUM_CNT; a++) readChk(a, 0, "R4 counters cleared");

    // R4 coincident event dropped
    drive(1'b1, 1'b0, 1'b1, '1, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b1, '1, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b1);
    for (int a = 0; a < NUM_CNT; a++) readChk(a, 0, "R4 event with reset not counted");

    // R6 saturation
    for (int i = 0; i < MAXV + 5; i++) drive(1'b1, 1'b0, (i < 2), 3'b010, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b1);
    readChk(0, MAXV, "R6 accepted saturates");
    readChk(1, 2, "R6 unsaturated neighbour intact");
    readChk(3, MAXV, "R6 command counter saturates");

    // R7 periodic disabled
    repeat (20) @(negedge clk);
    check(snapValid, 0, "R7 period zero gives no snapshot");

    // R7 periodic sweep
    for (int p = 1; p <= 6; p++) begin
      periodCfg = PERIOD_W'(p);
      for (int k = 1; k <= p; k++) begin
        @(negedge clk);
        check(snapValid, (k == p), $sformatf("R7 first period P=%0d edge %0d", p, k));
      end
      if (p >= 2) begin
        readChk(2, 0, "R7 read during periodic run");
        check(snapValid, 0, "R7 cleared after read");
        for (int k = 1; k <= p - 1; k++) begin
          @(negedge clk);
          check(snapValid, (k == p - 1), $sformatf("R7 second period P=%0d edge %0d", p, k));
        end
      end
      periodCfg = '0;
      readChk(0, MAXV, "R7 periodic snapshot content");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule